// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

A byte-wide, register-mapped asynchronous serial transmitter and receiver. Software picks the character format at run time through one mode byte: 7 or 8 data bits, parity off, even or odd, and one or two stop bits. A two-stage bit-rate generator derives the bit timing from the system clock. A fixed prescaler of 1, 4, 16 or 64 feeds a reload counter set by the rate register, and the result is a 16x oversampling tick shared by both directions.

The transmitter sends a start bit, the data least significant bit first, the optional parity bit and the stop bits. A byte written to the transmit data register waits there until the shifter is idle, so one byte can be queued behind the one being sent. The receiver oversamples the line and samples each bit at the middle of its 16 ticks. It loads received characters into the receive data register and records overrun, framing and parity problems.

Hardware sets the status flags and software clears them by writing 0. Three interrupt request outputs follow the flags under per-source enables in the control register.

Top module: `serial_port`

## Requirements
- R1: Register offsets on `bus_addr` are: 0 control, 1 mode, 2 rate, 3 status, 4 transmit data, 5 receive data. A write happens on a rising clock edge with `bus_we` high. `bus_rdata` shows the addressed register combinationally, and reading has no side effects. Control, mode and rate read back as written.
- R2: After reset the status register reads 0x84 (bit 7 transmit-empty and bit 2 transmit-end set, all others 0). `txd` is high, all interrupt outputs are low, and the control, mode, rate and receive data registers are 0.
- R3: The bit period is D × 32 × (rate + 1) system clocks, where D is 1, 4, 16 or 64 for mode bits 1:0 = 00, 01, 10 or 11.
- R4: A frame is a low start bit followed by the data, least significant bit first. The frame carries 8 data bits when mode bit 6 is 0 and the low 7 bits when it is 1. The line idles high.
- R5: When mode bit 5 is 1, a parity bit follows the data. It is even parity when mode bit 4 is 0 and odd parity when it is 1.
- R6: Mode bit 3 = 0 sends one high stop bit; mode bit 3 = 1 sends two.
- R7: Writing the transmit data register clears status bit 7. When control bit 5 (transmit enable) is 1 and the shifter is idle, the byte moves to the shifter and bit 7 sets again. With control bit 5 at 0 the byte stays pending and `txd` stays high.
- R8: Status bit 2 clears when a byte enters the shifter. It sets when the last stop bit ends and no byte is pending.
- R9: With control bit 4 (receive enable) at 1, a completed character sets status bit 6 and is placed in the receive data register (bit 7 reads 0 for 7-bit characters). With control bit 4 at 0, line activity changes nothing.
- R10: A character that completes while status bit 6 is set is discarded and sets status bit 5. The receive data register keeps the earlier character.
- R11: A low first stop bit sets status bit 4. A parity mismatch sets status bit 3. The character is still stored.
- R12: Writing the status register clears every flag written with 0 and leaves every flag written with 1 unchanged. Bits 1:0 always read 0.
- R13: `irq_tx_empty` = control bit 7 AND status bit 7. `irq_rx` = control bit 6 AND (status bit 6, 5, 4 or 3). `irq_tx_end` = control bit 2 AND status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq_tx_empty | output | 1 | Transmit data register empty request |
| irq_rx | output | 1 | Receive full or receive error request |
| irq_tx_end | output | 1 | End of transmission request |

## Verification
The transmitter is looped back into the receiver. Every combination of the four mode format bits is swept over several data bytes, and each `txd` bit is compared at mid-period against a frame built arithmetically in the bench.

A wrong shift or counter state in the transmitter shows on `txd` within one bit period. A receiver fault shows in the status and receive data registers within one character time. A broken prescaler or reload shows as a wrong low-time on `txd` within one frame. Error frames are driven directly on `rxd` to expose overrun, framing and parity flags and the write-0-to-clear rule.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int DW       = 8;
    localparam int MAX_BITS = 12;   // start + 8 data + parity + 2 stop

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_MODE = 3'd1,
        A_RATE = 3'd2,
        A_STAT = 3'd3,
        A_TXD  = 3'd4,
        A_RXD  = 3'd5
    } reg_addr_e;

    // Field order matches the status bit positions 7..0
    typedef struct packed {
        logic       tdre;
        logic       rdrf;
        logic       orer;
        logic       fer;
        logic       per;
        logic       tend;
        logic [1:0] rsv;
    } status_t;

    typedef struct packed {
        logic seven;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_mode(input logic [DW-1:0] m);
        frame_cfg_t c;
        c.seven    = m[6];
        c.par_en   = m[5];
        c.par_odd  = m[4];
        c.two_stop = m[3];
        return c;
    endfunction

    function automatic logic [3:0] frame_len(input frame_cfg_t c);
        return 4'd1 + (c.seven ? 4'd7 : 4'd8) + {3'b000, c.par_en}
                    + (c.two_stop ? 4'd2 : 4'd1);
    endfunction

    // Bit 0 goes out first; unused upper bits stay at the mark level
    function automatic logic [MAX_BITS-1:0] frame_bits(input logic [DW-1:0] d,
                                                       input frame_cfg_t c);
        logic [MAX_BITS-1:0] f;
        logic [DW-1:0]       dd;
        dd   = c.seven ? {1'b0, d[6:0]} : d;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < 7 || !c.seven) f[i+1] = dd[i];
        end
        if (c.par_en) f[c.seven ? 8 : 9] = (^dd) ^ c.par_odd;
        return f;
    endfunction
endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        presc,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [5:0]      pcnt, plim;
    logic [RATE_W:0] rcnt, rlim;

    always_comb begin
        case (presc)
            2'd0:    plim = 6'd0;
            2'd1:    plim = 6'd3;
            2'd2:    plim = 6'd15;
            default: plim = 6'd63;
        endcase
        rlim = {rate, 1'b1};   // 2*(rate+1) prescaled clocks per tick
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            rcnt <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (pcnt >= plim) begin
                pcnt <= '0;
                if (rcnt >= rlim) begin
                    rcnt <= '0;
                    tick <= 1'b1;
                end else begin
                    rcnt <= rcnt + 1'b1;
                end
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] data,
    input  frame_cfg_t    cfg,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    localparam int OW = $clog2(OVS);
    localparam logic [OW-1:0] SUB_LAST = OW'(OVS - 1);

    logic [MAX_BITS-1:0] sh;
    logic [3:0]          left;
    logic [OW-1:0]       sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            left <= '0;
            sub  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                sh   <= frame_bits(data, cfg);
                left <= frame_len(cfg);
                sub  <= '0;
            end else if (tick && left != 4'd0) begin
                if (sub == SUB_LAST) begin
                    sub  <= '0;
                    sh   <= {1'b1, sh[MAX_BITS-1:1]};
                    left <= left - 4'd1;
                    if (left == 4'd1) done <= 1'b1;
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end

    assign busy = (left != 4'd0);
    assign txd  = busy ? sh[0] : 1'b1;

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd); // R4
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  logic          rxd,
    input  logic          seven,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ferr
);
    localparam int OW = $clog2(OVS);
    localparam logic [OW-1:0] SUB_MID  = OW'(OVS / 2);
    localparam logic [OW-1:0] SUB_LAST = OW'(OVS - 1);

    logic          s1, s2, active, pbit;
    logic [OW-1:0] sub;
    logic [3:0]    idx, nd, last;
    logic [DW-1:0] rbuf, dd;

    assign nd   = seven ? 4'd7 : 4'd8;
    assign last = nd + {3'b000, par_en} + 4'd1;
    assign dd   = seven ? {1'b0, rbuf[DW-1:1]} : rbuf;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1; s2 <= 1'b1;
            active <= 1'b0; pbit <= 1'b0;
            sub <= '0; idx <= '0; rbuf <= '0;
            done <= 1'b0; data <= '0; perr <= 1'b0; ferr <= 1'b0;
        end else begin
            s1   <= rxd;
            s2   <= s1;
            done <= 1'b0;
            if (!en) begin
                active <= 1'b0;
            end else if (tick) begin
                if (!active) begin
                    if (!s2) begin
                        active <= 1'b1;
                        sub    <= OW'(1);
                        idx    <= '0;
                    end
                end else begin
                    sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
                    if (sub == SUB_MID) begin
                        idx <= idx + 4'd1;
                        if (idx == 4'd0) begin
                            if (s2) active <= 1'b0;      // false start
                        end else if (idx <= nd) begin
                            rbuf <= {s2, rbuf[DW-1:1]};
                        end else if (par_en && idx == nd + 4'd1) begin
                            pbit <= s2;
                        end
                        if (idx == last) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                            data   <= dd;
                            ferr   <= !s2;
                            perr   <= par_en & ((^dd) ^ pbit ^ par_odd);
                        end
                    end
                end
            end
        end
    end

    AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
endmodule

// File: rtl/serial_port.sv
module serial_port
    import sp_pkg::*;
#(
    parameter int RATE_W = 8,
    parameter int OVS    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       txd,
    input  logic       rxd,
    output logic       irq_tx_empty,
    output logic       irq_rx,
    output logic       irq_tx_end
);
    logic [DW-1:0]     ctl_q, mode_q, tdr_q, rdr_q;
    logic [RATE_W-1:0] rate_q;
    status_t           st_q, st_n;
    frame_cfg_t        cfg;
    logic              tick, tx_load, tx_busy, tx_done;
    logic              rx_done, rx_perr, rx_ferr;
    logic [DW-1:0]     rx_data;
    logic              wr_stat, wr_txd;

    assign cfg     = decode_mode(mode_q);
    assign wr_stat = bus_we && bus_addr == A_STAT;
    assign wr_txd  = bus_we && bus_addr == A_TXD;
    assign tx_load = ctl_q[5] && !st_q.tdre && !tx_busy;

    sp_baud #(.RATE_W(RATE_W)) u_baud (
        .clk(clk), .rst(rst), .presc(mode_q[1:0]), .rate(rate_q), .tick(tick)
    );

    sp_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .tick(tick), .load(tx_load), .data(tdr_q),
        .cfg(cfg), .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    sp_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .en(ctl_q[4]), .rxd(rxd),
        .seven(cfg.seven), .par_en(cfg.par_en), .par_odd(cfg.par_odd),
        .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
    );

    always_comb begin
        st_n = st_q;
        if (wr_stat) st_n = st_q & status_t'(bus_wdata);
        if (tx_load) begin
            st_n.tdre = 1'b1;
            st_n.tend = 1'b0;
        end
        if (wr_txd) st_n.tdre = 1'b0;
        if (tx_done && st_q.tdre && !wr_txd) st_n.tend = 1'b1;
        if (rx_done) begin
            if (st_q.rdrf) begin
                st_n.orer = 1'b1;
            end else begin
                st_n.rdrf = 1'b1;
                st_n.per  = st_n.per | rx_perr;
                st_n.fer  = st_n.fer | rx_ferr;
            end
        end
        st_n.rsv = 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            mode_q <= '0;
            rate_q <= '0;
            tdr_q  <= '0;
            rdr_q  <= '0;
            st_q   <= status_t'(8'h84);
        end else begin
            st_q <= st_n;
            if (bus_we) begin
                case (bus_addr)
                    A_CTRL:  ctl_q  <= bus_wdata;
                    A_MODE:  mode_q <= bus_wdata;
                    A_RATE:  rate_q <= bus_wdata[RATE_W-1:0];
                    A_TXD:   tdr_q  <= bus_wdata;
                    default: ;
                endcase
            end
            if (rx_done && !st_q.rdrf) rdr_q <= rx_data;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctl_q;
            A_MODE:  bus_rdata = mode_q;
            A_RATE:  bus_rdata = DW'(rate_q);
            A_STAT:  bus_rdata = st_q;
            A_TXD:   bus_rdata = tdr_q;
            A_RXD:   bus_rdata = rdr_q;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_tx_empty = ctl_q[7] & st_q.tdre;
    assign irq_rx       = ctl_q[6] & (st_q.rdrf | st_q.orer | st_q.fer | st_q.per);
    assign irq_tx_end   = ctl_q[2] & st_q.tend;

    AST_TDRE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        tx_load && !wr_txd |=> st_q.tdre); // R7
    AST_TEND_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        st_q.tend |-> !tx_busy); // R8
    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        rx_done && st_q.rdrf |=> $stable(rdr_q)); // R10
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        st_q.rsv == 2'b00); // R12
endmodule

// File: tb/sim_serial_port.sv
module sim_serial_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       txd, irq_tx_empty, irq_rx, irq_tx_end;
    logic       loop_en = 1'b1;
    logic       drv_rx = 1'b1;
    logic       rxd;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;
    assign rxd = loop_en ? txd : drv_rx;

    serial_port u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd),
        .irq_tx_empty(irq_tx_empty), .irq_rx(irq_rx), .irq_tx_end(irq_tx_end)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Frame as the requirements define it, bit 0 first on the line
    task automatic build(input logic [7:0] md, input logic [7:0] d,
                         output logic [11:0] e, output int len);
        int nd;
        logic [7:0] dm;
        nd  = md[6] ? 7 : 8;
        dm  = md[6] ? (d & 8'h7F) : d;
        e   = '1;
        len = 0;
        e[len] = 1'b0; len++;
        for (int i = 0; i < nd; i++) begin e[len] = dm[i]; len++; end
        if (md[5]) begin e[len] = (^dm) ^ md[4]; len++; end
        e[len] = 1'b1; len++;
        if (md[3]) begin e[len] = 1'b1; len++; end
    endtask

    task automatic expect_frame(input logic [7:0] md, input logic [7:0] d,
                                input int p, input string tag);
        logic [11:0] e, o, mask;
        int len, t;
        build(md, d, e, len);
        o = '1;
        t = 0;
        while (txd !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
        repeat (p / 2) @(negedge clk);
        o[0] = txd;
        for (int i = 1; i < len; i++) begin
            repeat (p) @(negedge clk);
            o[i] = txd;
        end
        mask = 12'((1 << len) - 1);
        chk(((o ^ e) & mask) == 12'd0, tag, int'(o & mask), int'(e & mask));
    endtask

    task automatic send_raw(input logic [11:0] bits, input int len, input int p);
        for (int i = 0; i < len; i++) begin
            drv_rx = bits[i];
            repeat (p) @(negedge clk);
        end
        drv_rx = 1'b1;
        repeat (2 * p) @(negedge clk);
    endtask

    initial begin
        logic [7:0]  v, d, md;
        logic [11:0] e;
        int          len, lowt, p;
        int          pv[4];
        int          rv[4];

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        rd(3'd3, v); chk(v == 8'h84, "R2 status after reset", v, 8'h84);
        rd(3'd5, v); chk(v == 8'h00, "R2 rx data after reset", v, 0);
        rd(3'd0, v); chk(v == 8'h00, "R2 control after reset", v, 0);
        rd(3'd1, v); chk(v == 8'h00, "R2 mode after reset", v, 0);
        rd(3'd2, v); chk(v == 8'h00, "R2 rate after reset", v, 0);
        chk(txd === 1'b1, "R2 txd idle after reset", txd, 1);
        chk({irq_tx_empty, irq_rx, irq_tx_end} == 3'b000, "R2 irqs after reset",
            {irq_tx_empty, irq_rx, irq_tx_end}, 0);

        // Sweep every format combination in loopback, rate 0, prescale 1
        wr(3'd0, 8'h30);
        for (int m = 0; m < 16; m++) begin
            md = 8'(m << 3);
            wr(3'd1, md);
            for (int k = 0; k < 3; k++) begin
                d = 8'(m * 37 + k * 91 + 5);
                wr(3'd4, d);
                rd(3'd3, v); chk(v[7] == 1'b0, "R7 tdre clears on write", v, 0);
                @(negedge clk);
                rd(3'd3, v); chk(v[7:6] == 2'b10 && v[2] == 1'b0,
                                 "R8 tdre set and tend cleared on load", v, 8'h80);
                expect_frame(md, d, 32, "R4 R5 R6 transmitted frame");
                idle(40);
                rd(3'd3, v); chk(v == 8'hC4, "R9 R8 status after loopback frame", v, 8'hC4);
                rd(3'd5, v);
                chk(v == (md[6] ? (d & 8'h7F) : d), "R9 received character",
                    v, md[6] ? (d & 8'h7F) : d);
                wr(3'd3, 8'hBF);
                rd(3'd3, v); chk(v == 8'h84, "R12 write 0 clears only rx full", v, 8'h84);
            end
        end

        // R1 register readback
        wr(3'd1, 8'h5B); rd(3'd1, v); chk(v == 8'h5B, "R1 mode readback", v, 8'h5B);
        wr(3'd2, 8'hA7); rd(3'd2, v); chk(v == 8'hA7, "R1 rate readback", v, 8'hA7);
        wr(3'd0, 8'h34); rd(3'd0, v); chk(v == 8'h34, "R1 control readback", v, 8'h34);
        wr(3'd0, 8'h30);

        // R3 bit period for each prescaler: 8N1 data 0 gives 9 low bit times
        pv = '{1, 4, 16, 64};
        rv = '{3, 1, 0, 0};
        for (int s = 0; s < 4; s++) begin
            p = pv[s] * 32 * (rv[s] + 1);
            wr(3'd1, 8'(s));
            wr(3'd2, 8'(rv[s]));
            wr(3'd4, 8'h00);
            lowt = 0;
            while (txd !== 1'b0 && lowt < 20000) begin @(negedge clk); lowt++; end
            lowt = 0;
            while (txd === 1'b0 && lowt < 40000) begin @(negedge clk); lowt++; end
            chk(lowt >= 9 * p - p / 16 - 2 && lowt <= 9 * p + 2,
                "R3 bit period from prescaler and rate", lowt, 9 * p);
            repeat (2 * p) @(negedge clk);
            wr(3'd3, 8'h84);
        end
        wr(3'd2, 8'h00);

        // Error cases driven directly on rxd
        loop_en = 1'b0;
        wr(3'd0, 8'h70);
        md = 8'h20;                      // 8 data, even parity, 1 stop
        wr(3'd1, md);
        build(md, 8'h01, e, len);
        e[9] = ~e[9];
        send_raw(e, len, 32);
        rd(3'd3, v); chk(v == 8'hCC, "R11 parity error flag", v, 8'hCC);
        rd(3'd5, v); chk(v == 8'h01, "R11 character kept on parity error", v, 1);
        chk(irq_rx === 1'b1, "R13 irq_rx on receive", irq_rx, 1);
        wr(3'd3, 8'h84);
        rd(3'd3, v); chk(v == 8'h84, "R12 clear after parity error", v, 8'h84);
        chk(irq_rx === 1'b0, "R13 irq_rx drops when cleared", irq_rx, 0);

        md = 8'h00;
        wr(3'd1, md);
        build(md, 8'h55, e, len);
        e[9] = 1'b0;
        send_raw(e, len, 32);
        rd(3'd3, v); chk(v == 8'hD4, "R11 framing error flag", v, 8'hD4);
        rd(3'd5, v); chk(v == 8'h55, "R11 character kept on framing error", v, 8'h55);
        wr(3'd3, 8'h84);

        build(md, 8'h11, e, len); send_raw(e, len, 32);
        build(md, 8'h22, e, len); send_raw(e, len, 32);
        rd(3'd3, v); chk(v == 8'hE4, "R10 overrun flag", v, 8'hE4);
        rd(3'd5, v); chk(v == 8'h11, "R10 overrun keeps first character", v, 8'h11);
        wr(3'd3, 8'hFF);
        rd(3'd3, v); chk(v == 8'hE4, "R12 writing 1 leaves flags", v, 8'hE4);
        wr(3'd3, 8'h84);
        rd(3'd3, v); chk(v == 8'h84, "R12 writing 0 clears flags", v, 8'h84);

        // R9 receiver disabled
        wr(3'd0, 8'h20);
        build(md, 8'h66, e, len); send_raw(e, len, 32);
        rd(3'd3, v); chk(v == 8'h84, "R9 receiver off leaves status", v, 8'h84);
        rd(3'd5, v); chk(v == 8'h11, "R9 receiver off leaves rx data", v, 8'h11);

        // R7 transmitter disabled holds the byte
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h5A);
        lowt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lowt++;
        end
        chk(lowt == 0, "R7 txd stays high with transmitter off", lowt, 0);
        rd(3'd3, v); chk(v == 8'h04, "R7 byte stays pending", v, 8'h04);
        wr(3'd0, 8'h20);
        expect_frame(md, 8'h5A, 32, "R7 pending byte sent after enable");
        idle(40);
        rd(3'd3, v); chk(v == 8'h84, "R8 tend after pending byte", v, 8'h84);

        // R13 interrupt gating
        wr(3'd0, 8'h84);
        chk({irq_tx_empty, irq_rx, irq_tx_end} == 3'b101, "R13 tx irqs enabled",
            {irq_tx_empty, irq_rx, irq_tx_end}, 3'b101);
        wr(3'd0, 8'h00);
        chk({irq_tx_empty, irq_rx, irq_tx_end} == 3'b000, "R13 irqs masked",
            {irq_tx_empty, irq_rx, irq_tx_end}, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule